// File: doc/BRIEF.md
# Bridged 64-bit Register Access Sequencer

This block sits on the master side of a register bridge. It turns one 64-bit read or write into a short series of 32-bit transfers on a request/acknowledge register bus. The bridge behind that bus offers mailbox registers: a high data word, a low data word, a command word, a status word and an engine-reset word. A client gives a 32-bit target address, a direction flag and 64 bits of write data. When the work is finished the block returns a one-cycle done pulse, a result code and 64 bits of read data.

Every access ends by reading the bridge status word. A status with the abort bit or any of the three error bits set counts as a failure. An all-ones status means the target has gone away, so the block clears its target-alive flag. Any other failure leads to a single write of zero to the engine-reset register. A failed transfer on the register bus itself stops the sequence at once. Requests made while the target is not alive are refused without touching the bus. An external init strobe marks the target alive.

Top module: `mbox_access_seq`

## Requirements
- R1: After reset, cl_busy, cl_done and rb_req are low and tgt_valid is low (target not alive).
- R2: A pulse on init_strobe sets tgt_valid. A request (cl_valid high while cl_busy is low) made while tgt_valid is low makes no bus transfer. It raises cl_done one cycle later with code 1 (parameter error) and cl_rdata all ones.
- R3: A write makes these transfers in order: write cl_wdata[63:32] to offset 0x1000, write cl_wdata[31:0] to offset 0x1004, write the address with bit 31 set to offset 0x1008, then read the status at offset 0x101C.
- R4: A read makes these transfers in order: write the address with bit 31 cleared to 0x1008, read the status at 0x101C, read 0x1000, then read 0x1004. On success it returns code 0 and cl_rdata = {word from 0x1000, word from 0x1004}.
- R5: A status word passes when bit 20 and bits 14:12 are all zero. Every other status bit is ignored.
- R6: A status of 0xFFFFFFFF ends the access with code 2 (hardware failure) and clears tgt_valid. No reset write and no data read follow it.
- R7: Any other failing status is followed by a write of zero to offset 0x101C's neighbour, the engine reset at 0x1018, and then code 2. On a read the data registers are not read. A bus error on that reset write still reports code 2.
- R8: A register-bus error on any transfer other than the reset write stops the sequence after that transfer with code 3 (bus error). No reset write is made.
- R9: rb_req stays high, with rb_addr, rb_we and rb_wdata unchanged, until the cycle rb_ack is seen. Only one transfer is outstanding at a time.
- R10: cl_busy rises on the clock edge that accepts a request and falls on the edge that raises cl_done. A cl_valid seen while busy is ignored. cl_done is a one-cycle pulse, high two cycles after the cycle of the final rb_ack.
- R11: cl_rdata is all ones after any failed or refused access and zero after a successful write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_strobe | input | 1 | Marks the target alive |
| cl_valid | input | 1 | Client request strobe |
| cl_write | input | 1 | 1 = write, 0 = read |
| cl_addr | input | 32 | Target register address |
| cl_wdata | input | 64 | Write data |
| cl_busy | output | 1 | Access in flight |
| cl_done | output | 1 | One-cycle completion pulse |
| cl_code | output | 2 | 0 ok, 1 parameter, 2 hardware, 3 bus error |
| cl_rdata | output | 64 | Read result |
| tgt_valid | output | 1 | Target-alive flag |
| rb_req | output | 1 | Register bus request |
| rb_we | output | 1 | Register bus write enable |
| rb_addr | output | 16 | Register bus offset |
| rb_wdata | output | 32 | Register bus write data |
| rb_ack | input | 1 | Register bus acknowledge |
| rb_err | input | 1 | Register bus error, valid with rb_ack |
| rb_rdata | input | 32 | Register bus read data, valid with rb_ack |

## Verification
A refused request shows cl_done exactly one cycle after the strobe. An accepted request shows cl_busy high one cycle after the strobe. Its cl_done comes exactly two cycles after the cycle of the last rb_ack, so the bench records the cycle of each acknowledge it drives and compares that count when done appears. The bench changes inputs and samples outputs only on falling edges. It checks code, data, the transfer log and the alive flag only after done, when all of them are settled.

// File: rtl/mbox_pkg.sv
// Package: shared result codes and sequencer states for the bridged
// register access sequencer. Assumes codes are a 2-bit field on the port.
package mbox_pkg;

    typedef enum logic [1:0] {
        RC_OK    = 2'd0,
        RC_PARAM = 2'd1,
        RC_HW    = 2'd2,
        RC_BUS   = 2'd3
    } rc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_HI,
        ST_WR_LO,
        ST_CMD,
        ST_STAT,
        ST_RD_HI,
        ST_RD_LO,
        ST_RESET
    } seq_st_t;

endpackage

// File: rtl/mbox_bus_port.sv
// Module: single-transfer register bus master.
// On a launch pulse it latches one transfer and holds the request until
// acknowledge. It then reports completion one cycle later with the captured
// error flag and read data. Assumes launch comes only while no transfer is open.
module mbox_bus_port #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          l_we,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic          rb_req,
    output logic          rb_we,
    output logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_wdata,
    input  logic          rb_ack,
    input  logic          rb_err,
    input  logic [DW-1:0] rb_rdata,
    output logic          fin,
    output logic          fin_err,
    output logic [DW-1:0] fin_rdata
);

    // Open, hold and close one bus transfer; report its outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_req    <= 1'b0;
            rb_we     <= 1'b0;
            rb_addr   <= '0;
            rb_wdata  <= '0;
            fin       <= 1'b0;
            fin_err   <= 1'b0;
            fin_rdata <= '0;
        end else begin
            fin <= 1'b0;
            if (launch && !rb_req) begin
                rb_req   <= 1'b1;
                rb_we    <= l_we;
                rb_addr  <= l_addr;
                rb_wdata <= l_wdata;
            end else if (rb_req && rb_ack) begin
                rb_req    <= 1'b0;
                fin       <= 1'b1;
                fin_err   <= rb_err;
                fin_rdata <= rb_rdata;
            end
        end
    end

endmodule

// File: rtl/mbox_status_eval.sv
// Module: combinational judge of the bridge status word.
// Pass needs the abort bit and the error field clear. Dead means all ones.
// Assumes the abort bit and error field lie inside the word.
module mbox_status_eval #(
    parameter int DW        = 32,
    parameter int ABORT_BIT = 20,
    parameter int ERR_LSB   = 12,
    parameter int ERR_W     = 3
) (
    input  logic [DW-1:0] stat,
    output logic          pass,
    output logic          dead
);

    localparam logic [DW-1:0] ABORT_MASK = DW'(1) << ABORT_BIT;
    localparam logic [DW-1:0] ERR_MASK   = ((DW'(1) << ERR_W) - DW'(1)) << ERR_LSB;
    localparam logic [DW-1:0] FAIL_MASK  = ABORT_MASK | ERR_MASK;

    // Classify the status word.
    always_comb begin
        pass = ((stat & FAIL_MASK) == '0);
        dead = (stat == '1);
    end

endmodule

// File: rtl/mbox_target_flag.sv
// Module: target-alive flag. The init strobe sets it and a dead status
// clears it; clearing wins if both arrive in one cycle. Starts cleared.
module mbox_target_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic alive
);

    // Hold the alive state.
    always_ff @(posedge clk) begin
        if (!rst_n)     alive <= 1'b0;
        else if (clr_i) alive <= 1'b0;
        else if (set_i) alive <= 1'b1;
    end

endmodule

// File: rtl/mbox_access_seq.sv
// Module: top of the bridged 64-bit register access sequencer.
// It accepts one client access at a time. It steps through the data,
// command, status, data-read and reset transfers on the register bus and
// returns a result code. Assumes the bridge answers every request
// eventually, and that cl_addr/cl_wdata need to be valid only in the
// accepting cycle.
module mbox_access_seq #(
    parameter int DW    = 32,
    parameter int RB_AW = 16,
    parameter logic [RB_AW-1:0] OFS_DHI  = 'h1000,
    parameter logic [RB_AW-1:0] OFS_DLO  = 'h1004,
    parameter logic [RB_AW-1:0] OFS_CMD  = 'h1008,
    parameter logic [RB_AW-1:0] OFS_RST  = 'h1018,
    parameter logic [RB_AW-1:0] OFS_STAT = 'h101C,
    parameter int ABORT_BIT = 20,
    parameter int ERR_LSB   = 12,
    parameter int ERR_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_strobe,
    input  logic              cl_valid,
    input  logic              cl_write,
    input  logic [DW-1:0]     cl_addr,
    input  logic [2*DW-1:0]   cl_wdata,
    output logic              cl_busy,
    output logic              cl_done,
    output logic [1:0]        cl_code,
    output logic [2*DW-1:0]   cl_rdata,
    output logic              tgt_valid,
    output logic              rb_req,
    output logic              rb_we,
    output logic [RB_AW-1:0]  rb_addr,
    output logic [DW-1:0]     rb_wdata,
    input  logic              rb_ack,
    input  logic              rb_err,
    input  logic [DW-1:0]     rb_rdata
);
    import mbox_pkg::*;

    localparam int CW = 2 * DW;
    localparam logic [DW-1:0] WR_FLAG = DW'(1) << (DW - 1);

    seq_st_t          st;
    logic             is_wr;
    logic [DW-1:0]    addr_q;
    logic [CW-1:0]    wdata_q;
    logic [DW-1:0]    hi_q;
    logic             launch;
    logic             busy_q;
    logic             done_q;
    rc_t              code_q;
    logic [CW-1:0]    rdata_q;

    logic             l_we;
    logic [RB_AW-1:0] l_addr;
    logic [DW-1:0]    l_wdata;
    logic             fin;
    logic             fin_err;
    logic [DW-1:0]    fin_rdata;
    logic             st_pass;
    logic             st_dead;
    logic             kill;

    mbox_bus_port #(.AW(RB_AW), .DW(DW)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .l_we      (l_we),
        .l_addr    (l_addr),
        .l_wdata   (l_wdata),
        .rb_req    (rb_req),
        .rb_we     (rb_we),
        .rb_addr   (rb_addr),
        .rb_wdata  (rb_wdata),
        .rb_ack    (rb_ack),
        .rb_err    (rb_err),
        .rb_rdata  (rb_rdata),
        .fin       (fin),
        .fin_err   (fin_err),
        .fin_rdata (fin_rdata)
    );

    mbox_status_eval #(
        .DW(DW), .ABORT_BIT(ABORT_BIT), .ERR_LSB(ERR_LSB), .ERR_W(ERR_W)
    ) u_eval (
        .stat (fin_rdata),
        .pass (st_pass),
        .dead (st_dead)
    );

    mbox_target_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (init_strobe),
        .clr_i (kill),
        .alive (tgt_valid)
    );

    // Dead-target detection on a completed, error-free status read.
    always_comb begin
        kill = (st == ST_STAT) && fin && !fin_err && st_dead;
    end

    // Transfer descriptor for the current step.
    always_comb begin
        l_we    = 1'b1;
        l_addr  = OFS_CMD;
        l_wdata = '0;
        unique case (st)
            ST_WR_HI: begin l_addr = OFS_DHI; l_wdata = wdata_q[CW-1:DW]; end
            ST_WR_LO: begin l_addr = OFS_DLO; l_wdata = wdata_q[DW-1:0]; end
            ST_CMD: begin
                l_addr  = OFS_CMD;
                l_wdata = is_wr ? (addr_q | WR_FLAG) : (addr_q & ~WR_FLAG);
            end
            ST_STAT:  begin l_we = 1'b0; l_addr = OFS_STAT; end
            ST_RD_HI: begin l_we = 1'b0; l_addr = OFS_DHI; end
            ST_RD_LO: begin l_we = 1'b0; l_addr = OFS_DLO; end
            ST_RESET: begin l_addr = OFS_RST; l_wdata = '0; end
            default:  begin l_we = 1'b0; l_addr = OFS_CMD; end
        endcase
    end

    // Sequence control: accept, step on each completion, and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            is_wr   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            hi_q    <= '0;
            launch  <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            code_q  <= RC_OK;
            rdata_q <= '0;
        end else begin
            launch <= 1'b0;
            done_q <= 1'b0;
            if (st == ST_IDLE) begin
                if (cl_valid) begin
                    if (!tgt_valid) begin
                        done_q  <= 1'b1;
                        code_q  <= RC_PARAM;
                        rdata_q <= '1;
                    end else begin
                        busy_q  <= 1'b1;
                        is_wr   <= cl_write;
                        addr_q  <= cl_addr;
                        wdata_q <= cl_wdata;
                        st      <= cl_write ? ST_WR_HI : ST_CMD;
                        launch  <= 1'b1;
                    end
                end
            end else if (fin) begin
                if (fin_err && st != ST_RESET) begin
                    st <= ST_IDLE; busy_q <= 1'b0; done_q <= 1'b1;
                    code_q <= RC_BUS; rdata_q <= '1;
                end else begin
                    unique case (st)
                        ST_WR_HI: begin st <= ST_WR_LO; launch <= 1'b1; end
                        ST_WR_LO: begin st <= ST_CMD;   launch <= 1'b1; end
                        ST_CMD:   begin st <= ST_STAT;  launch <= 1'b1; end
                        ST_STAT: begin
                            if (st_pass && is_wr) begin
                                st <= ST_IDLE; busy_q <= 1'b0; done_q <= 1'b1;
                                code_q <= RC_OK; rdata_q <= '0;
                            end else if (st_pass) begin
                                st <= ST_RD_HI; launch <= 1'b1;
                            end else if (st_dead) begin
                                st <= ST_IDLE; busy_q <= 1'b0; done_q <= 1'b1;
                                code_q <= RC_HW; rdata_q <= '1;
                            end else begin
                                st <= ST_RESET; launch <= 1'b1;
                            end
                        end
                        ST_RD_HI: begin
                            hi_q <= fin_rdata; st <= ST_RD_LO; launch <= 1'b1;
                        end
                        ST_RD_LO: begin
                            st <= ST_IDLE; busy_q <= 1'b0; done_q <= 1'b1;
                            code_q <= RC_OK; rdata_q <= {hi_q, fin_rdata};
                        end
                        ST_RESET: begin
                            st <= ST_IDLE; busy_q <= 1'b0; done_q <= 1'b1;
                            code_q <= RC_HW; rdata_q <= '1;
                        end
                        default: st <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    // Client-side outputs.
    always_comb begin
        cl_busy  = busy_q;
        cl_done  = done_q;
        cl_code  = code_q;
        cl_rdata = rdata_q;
    end

endmodule

// File: rtl/mbox_access_seq_chk.sv
// Module: property checker for the access sequencer, bound into the top.
module mbox_access_seq_chk #(
    parameter int DW    = 32,
    parameter int RB_AW = 16,
    parameter logic [RB_AW-1:0] OFS_DHI  = 'h1000,
    parameter logic [RB_AW-1:0] OFS_DLO  = 'h1004,
    parameter logic [RB_AW-1:0] OFS_CMD  = 'h1008,
    parameter logic [RB_AW-1:0] OFS_RST  = 'h1018,
    parameter logic [RB_AW-1:0] OFS_STAT = 'h101C
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cl_valid,
    input logic             cl_busy,
    input logic             cl_done,
    input logic [1:0]       cl_code,
    input logic             tgt_valid,
    input logic             rb_req,
    input logic             rb_we,
    input logic [RB_AW-1:0] rb_addr,
    input logic [DW-1:0]    rb_wdata,
    input logic             rb_ack,
    input logic             rb_err,
    input logic [DW-1:0]    rb_rdata
);

    // R9: request and its fields hold until acknowledged.
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rb_req && !rb_ack |=> rb_req && $stable(rb_addr) && $stable(rb_we) && $stable(rb_wdata));

    // R10: bus activity only inside an accepted access.
    assert_req_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rb_req |-> cl_busy);

    // R10: done never overlaps busy.
    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cl_done |-> !cl_busy);

    // R2: request while target not alive is refused next cycle.
    assert_refuse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cl_valid && !cl_busy && !tgt_valid |=> cl_done && cl_code == 2'd1);

    // R7: engine reset transfer is a write of zero.
    assert_reset_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rb_req && rb_addr == OFS_RST |-> rb_we && rb_wdata == '0);

    // R6: all-ones status clears the alive flag two cycles later.
    assert_dead_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rb_req && rb_ack && !rb_err && !rb_we && rb_addr == OFS_STAT && rb_rdata == '1
        |-> ##2 !tgt_valid);

    // R3: only the bridge offsets appear on the bus.
    assert_addr_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rb_req |-> (rb_addr == OFS_DHI || rb_addr == OFS_DLO || rb_addr == OFS_CMD ||
                    rb_addr == OFS_RST || rb_addr == OFS_STAT));

endmodule

bind mbox_access_seq mbox_access_seq_chk #(
    .DW(DW), .RB_AW(RB_AW), .OFS_DHI(OFS_DHI), .OFS_DLO(OFS_DLO),
    .OFS_CMD(OFS_CMD), .OFS_RST(OFS_RST), .OFS_STAT(OFS_STAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cl_valid  (cl_valid),
    .cl_busy   (cl_busy),
    .cl_done   (cl_done),
    .cl_code   (cl_code),
    .tgt_valid (tgt_valid),
    .rb_req    (rb_req),
    .rb_we     (rb_we),
    .rb_addr   (rb_addr),
    .rb_wdata  (rb_wdata),
    .rb_ack    (rb_ack),
    .rb_err    (rb_err),
    .rb_rdata  (rb_rdata)
);

// File: tb/mbox_access_seq_tb.sv
module mbox_access_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_strobe = 1'b0;
    logic        cl_valid = 1'b0;
    logic        cl_write = 1'b0;
    logic [31:0] cl_addr = '0;
    logic [63:0] cl_wdata = '0;
    logic        cl_busy, cl_done, tgt_valid;
    logic [1:0]  cl_code;
    logic [63:0] cl_rdata;
    logic        rb_req, rb_we;
    logic [15:0] rb_addr;
    logic [31:0] rb_wdata;
    logic        rb_ack = 1'b0;
    logic        rb_err = 1'b0;
    logic [31:0] rb_rdata = '0;

    mbox_access_seq u_dut (
        .clk(clk), .rst_n(rst_n), .init_strobe(init_strobe),
        .cl_valid(cl_valid), .cl_write(cl_write), .cl_addr(cl_addr),
        .cl_wdata(cl_wdata), .cl_busy(cl_busy), .cl_done(cl_done),
        .cl_code(cl_code), .cl_rdata(cl_rdata), .tgt_valid(tgt_valid),
        .rb_req(rb_req), .rb_we(rb_we), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
        .rb_ack(rb_ack), .rb_err(rb_err), .rb_rdata(rb_rdata)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // bridge model controls
    logic [31:0] stat_val = '0;
    logic [31:0] rd_hi = '0, rd_lo = '0;
    int          err_step = -1;
    int          step = 0;
    int          last_ack_cyc = 0;
    logic [15:0] lg_addr [0:7];
    logic        lg_we   [0:7];
    logic [31:0] lg_wd   [0:7];
    int          lg_n = 0;

    // expectation
    logic [15:0] e_addr [0:7];
    logic        e_we   [0:7];
    logic [31:0] e_wd   [0:7];
    int          e_n;
    logic [1:0]  e_code;
    logic [63:0] e_rd;
    bit          exp_valid = 1'b0;

    localparam logic [31:0] FAILM = 32'h0010_7000;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // bridge responder: acknowledges requests after 0..2 idle cycles
    initial begin
        int wcnt;
        wcnt = 0;
        forever begin
            @(negedge clk);
            if (rb_ack) begin
                rb_ack = 1'b0;
                rb_err = 1'b0;
            end else if (rb_req) begin
                if (wcnt == 0) begin
                    rb_ack = 1'b1;
                    rb_err = (step == err_step);
                    case (rb_addr)
                        16'h101C: rb_rdata = stat_val;
                        16'h1000: rb_rdata = rd_hi;
                        16'h1004: rb_rdata = rd_lo;
                        default:  rb_rdata = $urandom;
                    endcase
                    if (lg_n < 8) begin
                        lg_addr[lg_n] = rb_addr;
                        lg_we[lg_n]   = rb_we;
                        lg_wd[lg_n]   = rb_wdata;
                    end
                    lg_n++;
                    step++;
                    last_ack_cyc = cyc;
                    wcnt = $urandom % 3;
                end else begin
                    wcnt--;
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R10 act=hung exp=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic push(input bit w, input logic [15:0] a, input logic [31:0] d);
        e_addr[e_n] = a;
        e_we[e_n]   = w;
        e_wd[e_n]   = d;
        e_n++;
    endtask

    // expected transfer list, code and data from the requirements
    task automatic build_exp(input bit w, input logic [31:0] a, input logic [63:0] d);
        e_n = 0;
        e_code = 2'd0;
        e_rd = '1;
        if (!exp_valid) begin
            e_code = 2'd1;
            return;
        end
        if (w) begin
            push(1'b1, 16'h1000, d[63:32]);
            if (err_step == 0) begin e_code = 2'd3; return; end
            push(1'b1, 16'h1004, d[31:0]);
            if (err_step == 1) begin e_code = 2'd3; return; end
            push(1'b1, 16'h1008, a | 32'h8000_0000);
            if (err_step == 2) begin e_code = 2'd3; return; end
        end else begin
            push(1'b1, 16'h1008, a & 32'h7FFF_FFFF);
            if (err_step == 0) begin e_code = 2'd3; return; end
        end
        push(1'b0, 16'h101C, 32'h0);
        if (err_step == e_n - 1) begin e_code = 2'd3; return; end
        if ((stat_val & FAILM) == 0) begin
            if (w) begin
                e_rd = '0;
            end else begin
                push(1'b0, 16'h1000, 32'h0);
                if (err_step == e_n - 1) begin e_code = 2'd3; return; end
                push(1'b0, 16'h1004, 32'h0);
                if (err_step == e_n - 1) begin e_code = 2'd3; return; end
                e_rd = {rd_hi, rd_lo};
            end
        end else if (stat_val == 32'hFFFF_FFFF) begin
            e_code = 2'd2;
            exp_valid = 1'b0;
        end else begin
            push(1'b1, 16'h1018, 32'h0);
            e_code = 2'd2;
        end
    endtask

    task automatic do_access(input string tag, input bit w, input logic [31:0] a,
                             input logic [63:0] d, input int hold);
        int start;
        int lim;
        bit acc;
        bit seq_ok;
        acc = exp_valid;
        build_exp(w, a, d);
        lg_n = 0;
        step = 0;
        @(negedge clk);
        cl_valid = 1'b1;
        cl_write = w;
        cl_addr  = a;
        cl_wdata = d;
        start = cyc;
        @(negedge clk);
        if (acc) begin
            chk({tag, " R10 busy after accept"}, cl_busy == 1'b1, 64'(cl_busy), 64'd1);
            for (int h = 1; h < hold; h++) begin
                @(negedge clk);
                cl_addr = ~a;
                cl_write = ~w;
            end
        end
        cl_valid = 1'b0;
        lim = 0;
        while (!cl_done && lim < 300) begin
            @(negedge clk);
            lim++;
        end
        chk({tag, " R10 done seen"}, cl_done == 1'b1, 64'(cl_done), 64'd1);
        if (acc)
            chk({tag, " R10 done latency"}, cyc - last_ack_cyc == 2, 64'(cyc - last_ack_cyc), 64'd2);
        else
            chk({tag, " R2 refuse latency"}, cyc - start == 1, 64'(cyc - start), 64'd1);
        chk({tag, " code"}, cl_code == e_code, 64'(cl_code), 64'(e_code));
        chk({tag, " R11 rdata"}, cl_rdata == e_rd, cl_rdata, e_rd);
        seq_ok = (lg_n == e_n);
        for (int i = 0; i < 8; i++) begin
            if (seq_ok && i < e_n) begin
                if (lg_addr[i] != e_addr[i] || lg_we[i] != e_we[i] ||
                    (e_we[i] && lg_wd[i] != e_wd[i]))
                    seq_ok = 1'b0;
            end
        end
        chk({tag, " R9 transfer list"}, seq_ok, 64'(lg_n), 64'(e_n));
        chk({tag, " R6 alive flag"}, tgt_valid == exp_valid, 64'(tgt_valid), 64'(exp_valid));
        @(negedge clk);
        chk({tag, " R10 done one cycle"}, cl_done == 1'b0, 64'(cl_done), 64'd0);
    endtask

    task automatic do_init();
        @(negedge clk);
        init_strobe = 1'b1;
        @(negedge clk);
        init_strobe = 1'b0;
        exp_valid = 1'b1;
        chk("R2 init sets alive", tgt_valid == 1'b1, 64'(tgt_valid), 64'd1);
    endtask

    task automatic set_bridge(input logic [31:0] s, input int e);
        stat_val = s;
        err_step = e;
        rd_hi = $urandom;
        rd_lo = $urandom;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 busy reset", cl_busy == 1'b0, 64'(cl_busy), 64'd0);
        chk("R1 done reset", cl_done == 1'b0, 64'(cl_done), 64'd0);
        chk("R1 req reset", rb_req == 1'b0, 64'(rb_req), 64'd0);
        chk("R1 alive reset", tgt_valid == 1'b0, 64'(tgt_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        set_bridge(32'h0, -1);
        do_access("R2 refused before init", 1'b1, 32'h0001_2345, 64'h1111_2222_3333_4444, 1);
        do_init();

        set_bridge(32'h0, -1);
        do_access("R3 write ok", 1'b1, 32'h0201_15CF, 64'hDEAD_BEEF_0123_4567, 1);
        set_bridge(32'h0, -1);
        do_access("R4 read ok", 1'b0, 32'hF00F_000F, 64'h0, 2);
        set_bridge(32'hFFEF_8FFF, -1);
        do_access("R5 ignored bits read", 1'b0, 32'h0000_1234, 64'h0, 1);
        set_bridge(32'h0010_0000, -1);
        do_access("R7 abort on read", 1'b0, 32'h0000_0042, 64'h0, 1);
        set_bridge(32'h0000_1000, -1);
        do_access("R7 error bit12 write", 1'b1, 32'h0000_0043, 64'h5555_AAAA_5555_AAAA, 1);
        set_bridge(32'h0000_4000, 4);
        do_access("R7 reset bus error", 1'b1, 32'h0000_0044, 64'h1, 1);
        set_bridge(32'h0, 1);
        do_access("R8 status bus error", 1'b0, 32'h0000_0045, 64'h0, 1);
        set_bridge(32'h0, 3);
        do_access("R8 data low bus error", 1'b0, 32'h0000_0046, 64'h0, 1);
        set_bridge(32'hFFFF_FFFF, -1);
        do_access("R6 dead on write", 1'b1, 32'h0000_0047, 64'h2, 1);
        set_bridge(32'h0, -1);
        do_access("R2 refused after dead", 1'b0, 32'h0000_0048, 64'h0, 1);
        do_init();

        for (int k = 0; k < 60; k++) begin
            int sel;
            logic [31:0] s;
            int e;
            sel = $urandom % 20;
            e = -1;
            s = $urandom & ~FAILM;
            if (sel < 3) s = s | (32'h1 << (12 + ($urandom % 3)));
            else if (sel < 5) s = s | 32'h0010_0000;
            else if (sel == 5) s = 32'hFFFF_FFFF;
            else if (sel < 8) e = $urandom % 5;
            set_bridge(s, e);
            do_access("R5 random", 1'($urandom), $urandom, {$urandom, $urandom}, 1 + ($urandom % 2));
            if (!exp_valid) begin
                set_bridge(32'h0, -1);
                do_access("R2 random refuse", 1'b1, $urandom, 64'h0, 1);
                do_init();
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule